// File: doc/BRIEF.md
# RC Oscillator Trim Search Controller

This block chooses a 10-bit trim code for an on-chip RC oscillator right after reset, before any logic depends on that clock. The code sense is inverted: 0x000 gives the fastest oscillator and 0x3FF gives the slowest. A larger code therefore always means a slower clock.

The block runs a successive-approximation (binary) search. The first trial code is 0x200. For each trial it raises a one-cycle step request. An external frequency comparator counts oscillator edges over a reference window. It then answers with a valid strobe and a "too fast" flag. After ten answers the block pulses done for one cycle and keeps the final code on its output.

A bypass path lets a trim value saved earlier for the present supply range be applied straight away, with no search.

The machine has four states:
- **IDLE** waits for a command.
- **REQ** presents a trial code and pulses the step request.
- **WAIT** waits for the comparator answer.
- **DONE** pulses done.

Its transitions are:
- **IDLE→REQ** on start. The code becomes 0x200.
- **IDLE→DONE** on load, when start is low. The code becomes the stored value.
- **REQ→WAIT** always, after one cycle.
- **WAIT→REQ** on an answer when bits remain.
- **WAIT→DONE** on the answer for bit 0.
- **DONE→IDLE** always, after one cycle.

Top module: `rc_trim_search`

## Requirements
- R1: While reset is asserted and after it is released, `trim_o` is 0x200, and `step_req_o` and `done_o` are 0.
- R2: A start in IDLE sets `trim_o` to 0x200 and raises `step_req_o` for exactly one cycle, in the cycle after the start is sampled.
- R3: On a comparator answer (`cmp_valid_i`=1) in WAIT, the bit under test stays 1 if `cmp_fast_i`=1 and is cleared if `cmp_fast_i`=0. The next lower bit is then set to 1 and a new step request follows one cycle later.
- R4: A search takes exactly 10 step requests. `done_o` is then 1 for one cycle, and `trim_o` stays unchanged until the next start or load.
- R5: With a comparator that reports "too fast" exactly when the trial code is below a threshold T, the final code is T−1. If T is 0 the final code is 0x000; if T is 1024 or more it is 0x3FF.
- R6: A start or a load received while a search is running has no effect on the code sequence or on the result.
- R7: A load in IDLE, with start low, places `load_code_i` on `trim_o` in the next cycle. `done_o` pulses for that one cycle, and no step request occurs.
- R8: A comparator answer received while no step is outstanding leaves `trim_o` unchanged.
- R9: When start and load are both high in IDLE, start wins and a search begins from 0x200.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (sampled in IDLE) |
| load_i | input | 1 | Apply the stored code instead of searching |
| load_code_i | input | 10 | Stored trim value for the present supply range |
| cmp_valid_i | input | 1 | Comparator answer strobe |
| cmp_fast_i | input | 1 | 1 = oscillator too fast at the current code |
| trim_o | output | 10 | Current trim code (0x000 fastest, 0x3FF slowest) |
| step_req_o | output | 1 | One-cycle request to measure the current code |
| done_o | output | 1 | One-cycle pulse when the code is final |

## Verification
A wrong bit pointer or a wrong state does not surface slowly. It shows up at the ports on the next step request, either as a trial code whose set bits are wrong or as a request that arrives early or late. It can also show up as the wrong number of requests before done. A wrong keep-or-clear decision first alters the trial code in the cycle after the answer is taken. It then carries through to the final code, which the bench checks against the threshold it chose. The bench compares every output against its reference model on every clock, so any such fault is reported within one cycle of appearing.

// File: rtl/rc_trim_pkg.sv
package rc_trim_pkg;
    localparam int TRIM_W = 10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } trim_state_e;
endpackage

// File: rtl/rc_trim_fsm.sv
module rc_trim_fsm
    import rc_trim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        load_i,
    input  logic        cmp_valid_i,
    input  logic        last_bit_i,
    output trim_state_e state_o,
    output logic        init_o,
    output logic        apply_o,
    output logic        load_o,
    output logic        step_req_o,
    output logic        done_o,
    output logic        idle_o
);
    trim_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and datapath strobes
    always_comb begin
        state_d = state_q;
        init_o  = 1'b0;
        apply_o = 1'b0;
        load_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    init_o  = 1'b1;
                    state_d = ST_REQ;
                end else if (load_i) begin
                    load_o  = 1'b1;
                    state_d = ST_DONE;
                end
            end
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (cmp_valid_i) begin
                    apply_o = 1'b1;
                    state_d = last_bit_i ? ST_DONE : ST_REQ;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        step_req_o = (state_q == ST_REQ);
        done_o     = (state_q == ST_DONE);
        idle_o     = (state_q == ST_IDLE);
        state_o    = state_q;
    end
endmodule

// File: rtl/rc_trim_sar.sv
module rc_trim_sar #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         apply_i,
    input  logic         fast_i,
    input  logic         load_i,
    input  logic [W-1:0] load_code_i,
    output logic [W-1:0] code_o,
    output logic         last_bit_o
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] code_q, ptr_q;
    logic [W-1:0] code_step, ptr_step;

    // per-bit decision: keep or drop the bit under test, arm the next one
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic kept;
        assign kept = fast_i ? code_q[g] : (code_q[g] & ~ptr_q[g]);
        if (g == W - 1) begin : g_top
            assign code_step[g] = kept;
            assign ptr_step[g]  = 1'b0;
        end else begin : g_low
            assign code_step[g] = kept | ptr_q[g+1];
            assign ptr_step[g]  = ptr_q[g+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= MID;
            ptr_q  <= MID;
        end else if (init_i) begin
            code_q <= MID;
            ptr_q  <= MID;
        end else if (load_i) begin
            code_q <= load_code_i;
        end else if (apply_i) begin
            code_q <= code_step;
            ptr_q  <= ptr_step;
        end
    end

    assign code_o     = code_q;
    assign last_bit_o = ptr_q[0];
endmodule

// File: rtl/rc_trim_search.sv
module rc_trim_search
    import rc_trim_pkg::*;
#(
    parameter int CODE_W = TRIM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              load_i,
    input  logic [CODE_W-1:0] load_code_i,
    input  logic              cmp_valid_i,
    input  logic              cmp_fast_i,
    output logic [CODE_W-1:0] trim_o,
    output logic              step_req_o,
    output logic              done_o
);
    trim_state_e state;
    logic init_s, apply_s, load_s, last_bit, idle;

    rc_trim_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .load_i     (load_i),
        .cmp_valid_i(cmp_valid_i),
        .last_bit_i (last_bit),
        .state_o    (state),
        .init_o     (init_s),
        .apply_o    (apply_s),
        .load_o     (load_s),
        .step_req_o (step_req_o),
        .done_o     (done_o),
        .idle_o     (idle)
    );

    rc_trim_sar #(.W(CODE_W)) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_s),
        .apply_i    (apply_s),
        .fast_i     (cmp_fast_i),
        .load_i     (load_s),
        .load_code_i(load_code_i),
        .code_o     (trim_o),
        .last_bit_o (last_bit)
    );
endmodule

// File: rtl/rc_trim_search_chk.sv
module rc_trim_search_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              load_i,
    input logic [CODE_W-1:0] load_code_i,
    input logic              cmp_valid_i,
    input logic [CODE_W-1:0] trim_o,
    input logic              step_req_o,
    input logic              done_o,
    input logic              idle_i
);
    assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |=> !step_req_o);

    assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && start_i) |=> (step_req_o && trim_o == {1'b1, {(CODE_W-1){1'b0}}}));

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && step_req_o));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !start_i && !load_i) |=> $stable(trim_o));

    assert_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i && !cmp_valid_i) |=> $stable(trim_o));

    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && load_i && !start_i) |=> (done_o && trim_o == $past(load_code_i)));

    assert_stray_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !start_i && !load_i && cmp_valid_i) |=> $stable(trim_o));
endmodule

bind rc_trim_search rc_trim_search_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .load_i     (load_i),
    .load_code_i(load_code_i),
    .cmp_valid_i(cmp_valid_i),
    .trim_o     (trim_o),
    .step_req_o (step_req_o),
    .done_o     (done_o),
    .idle_i     (idle)
);

// File: tb/rc_trim_search_bench.sv
module rc_trim_search_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       load_i = 1'b0;
    logic [9:0] load_code_i = '0;
    logic       cmp_valid_i = 1'b0;
    logic       cmp_fast_i = 1'b0;
    logic [9:0] trim_o;
    logic       step_req_o, done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    rc_trim_search u_rc_trim_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .load_code_i(load_code_i), .cmp_valid_i(cmp_valid_i),
        .cmp_fast_i(cmp_fast_i), .trim_o(trim_o),
        .step_req_o(step_req_o), .done_o(done_o)
    );

    // behavioural reference: phase 0 idle, 1 request, 2 waiting, 3 finished
    int m_phase = 0;
    int m_code  = 512;
    int m_step  = 512;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_code = 512; m_step = 512;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                       m_code = 512; m_step = 512; m_phase = 1;
                   end else if (load_i) begin
                       m_code = int'(load_code_i); m_phase = 3;
                   end
                1: m_phase = 2;
                2: if (cmp_valid_i) begin
                       if (!cmp_fast_i) m_code = m_code - m_step;
                       if (m_step == 1) m_phase = 3;
                       else begin
                           m_step = m_step / 2;
                           m_code = m_code + m_step;
                           m_phase = 1;
                       end
                   end
                default: m_phase = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(int'(trim_o) == m_code, "R3 trim", int'(trim_o), m_code);
            check(step_req_o == (m_phase == 1), "R2 step_req", int'(step_req_o), int'(m_phase == 1));
            check(done_o == (m_phase == 3), "R4 done", int'(done_o), int'(m_phase == 3));
        end
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_search(input int target, input int lat, input bit inject);
        int steps = 0;
        int guard = 0;
        bit seen = 0;
        int exp;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!seen && guard < 400) begin
            if (done_o) seen = 1;
            else if (step_req_o) begin
                steps++;
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    start_i = inject; load_i = inject; load_code_i = 10'h155;
                end
                start_i = 1'b0; load_i = 1'b0;
                cmp_valid_i = 1'b1;
                cmp_fast_i  = (int'(trim_o) < target);
                @(negedge clk);
                cmp_valid_i = 1'b0;
            end else @(negedge clk);
            guard++;
        end
        exp = (target <= 0) ? 0 : ((target > 1023) ? 1023 : target - 1);
        check(steps == 10, "R4 step count", steps, 10);
        check(int'(trim_o) == exp, inject ? "R6 result" : "R5 result", int'(trim_o), exp);
        @(negedge clk);
        check(int'(trim_o) == exp && !done_o, "R4 hold", int'(trim_o), exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(trim_o == 10'h200 && !step_req_o && !done_o, "R1 in reset", int'(trim_o), 'h200);
        rst_n = 1'b1;
        @(negedge clk);
        check(trim_o == 10'h200 && !step_req_o && !done_o, "R1 after reset", int'(trim_o), 'h200);

        run_search(0, 1, 0);
        run_search(1024, 2, 0);
        run_search('h155, 1, 0);
        run_search('h2AB, 3, 0);
        run_search('h201, 1, 0);
        run_search('h0C3, 2, 1);

        // R7: load bypass
        @(negedge clk); load_i = 1'b1; load_code_i = 10'h0A5;
        @(negedge clk); load_i = 1'b0;
        check(trim_o == 10'h0A5 && done_o && !step_req_o, "R7 load", int'(trim_o), 'h0A5);
        @(negedge clk);
        check(trim_o == 10'h0A5 && !done_o, "R7 hold", int'(trim_o), 'h0A5);

        // R8: stray comparator answer in idle
        cmp_valid_i = 1'b1; cmp_fast_i = 1'b0;
        @(negedge clk); cmp_valid_i = 1'b0;
        @(negedge clk);
        check(trim_o == 10'h0A5 && !step_req_o, "R8 stray answer", int'(trim_o), 'h0A5);

        // R9: start and load together
        start_i = 1'b1; load_i = 1'b1; load_code_i = 10'h3C3;
        @(negedge clk); start_i = 1'b0; load_i = 1'b0;
        check(trim_o == 10'h200 && step_req_o && !done_o, "R9 start wins", int'(trim_o), 'h200);
        begin
            int g = 0;
            while (!done_o && g < 100) begin
                if (step_req_o) begin
                    @(negedge clk);
                    cmp_valid_i = 1'b1; cmp_fast_i = 1'b1;
                    @(negedge clk);
                    cmp_valid_i = 1'b0;
                end else @(negedge clk);
                g++;
            end
        end
        check(trim_o == 10'h3FF, "R9 search result", int'(trim_o), 'h3FF);
        repeat (3) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule